// File: doc/BRIEF.md
# Fine-Step Ramp Code Generator

This block produces the digital code sequence for a linear ramp played out by a wide waveform DAC during converter linearity tests. Software sets a base code, a span in DAC LSBs, a number of steps and a number of passes, then pulses `start`. The block splits the span into an integer step and a fractional part with a serial divider. It then moves one ramp point forward on every stimulus-update pulse `upd`. Because a step is usually a non-integer number of LSBs (a 20-bit DAC swept over about 1.03 million LSBs in 409,600 steps moves about 2.51 LSBs a step), a remainder accumulator carries the fractional part. The ramp therefore stays exactly linear and lands on the last code with no drift.

After the last step of a pass, the block flags the end for one cycle. On the next update it restarts at the base code for another pass. After the final pass it stops and keeps the last code.

Top module: `ramp_codegen`

## Requirements
- R1: While reset is held, and until the first accepted start after it, `code_out` is 0 and `ramp_ready`, `ramp_done` and `ramp_end` are all 0.
- R2: A `start` pulse is accepted only when the block is idle or done and `cfg_steps` is nonzero. On acceptance, `code_out` takes `cfg_start_code` at the next clock edge. `ramp_ready` then rises exactly CODE_W+1 clock edges after the accepting edge. A `start` with `cfg_steps` equal to 0 changes nothing.
- R3: With `ramp_ready` high and within a pass, each `upd` pulse moves from point i to point i+1. Point i has code = base + floor(i*span/N), where base, span and N are the values captured at the accepted start. The code is unsigned offset binary of width CODE_W.
- R4: The update that reaches point N sets `code_out` to exactly base+span. In the same cycle, `ramp_end` is high for exactly one clock.
- R5: `cfg_loops` sets the number of passes, and a value of 0 counts as 1. After a non-final pass, the next `upd` reloads `code_out` to base (point 0). After the final pass, `ramp_done` goes high, `ramp_ready` goes low and `code_out` holds base+span. `ramp_ready` and `ramp_done` are never high together.
- R6: `upd` has no effect while `ramp_ready` is low, that is while idle, dividing or done. `code_out` is unchanged.
- R7: Changes to the `cfg_*` inputs after an accepted start have no effect on the running sequence.
- R8: A `start` pulse while dividing or running is ignored.
- R9: A `start` accepted from the done state begins a fresh ramp with the newly captured configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start_code | input | CODE_W | Base code of the ramp |
| cfg_span | input | CODE_W | Ramp height in DAC LSBs |
| cfg_steps | input | STEP_W | Number of steps per pass |
| cfg_loops | input | LOOP_W | Number of passes (0 means 1) |
| start | input | 1 | Capture configuration and begin |
| upd | input | 1 | Stimulus-update pulse, one step per cycle high |
| code_out | output | CODE_W | DAC code |
| ramp_ready | output | 1 | Ramp is accepting updates |
| ramp_done | output | 1 | All passes finished |
| ramp_end | output | 1 | One-cycle pulse on the last point of a pass |

## Verification
Three ramps exercise the stepping. The first has a large span over few steps, so each step covers many LSBs with a small remainder. The second has a span smaller than the step count, so the integer step is zero and only the accumulator carry moves the code. The third has a zero span. Updates arrive both back-to-back and with gaps, which separates per-cycle stepping from per-pulse stepping. Updates sent during the divide phase and after completion check that they are ignored. `start` pulses and configuration changes made mid-ramp check that the captured values stay in force, and a restart from done checks reload.

// File: rtl/ramp_codegen_pkg.sv
package ramp_codegen_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_DIV  = 3'd1,
    ST_RUN  = 3'd2,
    ST_HOLD = 3'd3,
    ST_DONE = 3'd4
  } ramp_state_e;
endpackage

// File: rtl/ramp_rst_sync.sv
module ramp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/ramp_divider.sv
// Restoring serial divider: one quotient bit per cycle, DVD_W cycles.
module ramp_divider #(
  parameter int DVD_W = 20,
  parameter int DVS_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [DVD_W-1:0] dividend,
  input  logic [DVS_W-1:0] divisor,
  output logic             done,
  output logic [DVD_W-1:0] quotient,
  output logic [DVS_W-1:0] remainder
);
  localparam int CNT_W = (DVD_W > 1) ? $clog2(DVD_W) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DVD_W - 1);

  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DVD_W-1:0] dvd_q, dvd_d;
  logic [DVD_W-1:0] quo_q, quo_d;
  logic [DVS_W-1:0] rem_q, rem_d;
  logic [DVS_W-1:0] dvs_q, dvs_d;
  logic [DVS_W:0]   trial;
  logic [DVS_W:0]   diff;
  logic             fits;

  always_comb begin
    trial  = {rem_q, dvd_q[DVD_W-1]};
    diff   = trial - {1'b0, dvs_q};
    fits   = (trial >= {1'b0, dvs_q});
    busy_d = busy_q;
    done_d = 1'b0;
    cnt_d  = cnt_q;
    dvd_d  = dvd_q;
    quo_d  = quo_q;
    rem_d  = rem_q;
    dvs_d  = dvs_q;
    if (go) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      dvd_d  = dividend;
      dvs_d  = divisor;
      rem_d  = '0;
      quo_d  = '0;
    end else if (busy_q) begin
      rem_d = fits ? diff[DVS_W-1:0] : trial[DVS_W-1:0];
      quo_d = {quo_q[DVD_W-2:0], fits};
      dvd_d = {dvd_q[DVD_W-2:0], 1'b0};
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST_CNT) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      dvd_q  <= '0;
      quo_q  <= '0;
      rem_q  <= '0;
      dvs_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
      dvd_q  <= dvd_d;
      quo_q  <= quo_d;
      rem_q  <= rem_d;
      dvs_q  <= dvs_d;
    end
  end

  assign done      = done_q;
  assign quotient  = quo_q;
  assign remainder = rem_q;
endmodule

// File: rtl/ramp_stepper.sv
// Code register plus fractional remainder accumulator.
module ramp_stepper #(
  parameter int CODE_W = 20,
  parameter int STEP_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              rewind,
  input  logic              adv,
  input  logic [CODE_W-1:0] base_in,
  input  logic [CODE_W-1:0] quo,
  input  logic [STEP_W-1:0] rem,
  input  logic [STEP_W-1:0] steps,
  output logic [CODE_W-1:0] code,
  output logic              at_last
);
  logic [CODE_W-1:0] base_q, base_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic [STEP_W-1:0] idx_q, idx_d;
  logic [STEP_W-1:0] acc_q, acc_d;
  logic [STEP_W:0]   sum;
  logic [STEP_W:0]   sum_wrapped;
  logic              carry;

  always_comb begin
    sum         = {1'b0, acc_q} + {1'b0, rem};
    sum_wrapped = sum - {1'b0, steps};
    carry       = (sum >= {1'b0, steps});
    base_d = base_q;
    code_d = code_q;
    idx_d  = idx_q;
    acc_d  = acc_q;
    if (load) begin
      base_d = base_in;
      code_d = base_in;
      idx_d  = '0;
      acc_d  = '0;
    end else if (rewind) begin
      code_d = base_q;
      idx_d  = '0;
      acc_d  = '0;
    end else if (adv) begin
      code_d = code_q + quo + CODE_W'(carry);
      idx_d  = idx_q + 1'b1;
      acc_d  = carry ? sum_wrapped[STEP_W-1:0] : sum[STEP_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      code_q <= '0;
      idx_q  <= '0;
      acc_q  <= '0;
    end else begin
      base_q <= base_d;
      code_q <= code_d;
      idx_q  <= idx_d;
      acc_q  <= acc_d;
    end
  end

  assign code    = code_q;
  assign at_last = (idx_q == steps - 1'b1);
endmodule

// File: rtl/ramp_codegen.sv
module ramp_codegen #(
  parameter int CODE_W = 20,
  parameter int STEP_W = 20,
  parameter int LOOP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] cfg_start_code,
  input  logic [CODE_W-1:0] cfg_span,
  input  logic [STEP_W-1:0] cfg_steps,
  input  logic [LOOP_W-1:0] cfg_loops,
  input  logic              start,
  input  logic              upd,
  output logic [CODE_W-1:0] code_out,
  output logic              ramp_ready,
  output logic              ramp_done,
  output logic              ramp_end
);
  import ramp_codegen_pkg::*;

  logic              rst_n_i;
  ramp_state_e       state_q, state_d;
  logic [STEP_W-1:0] steps_q, steps_d;
  logic [LOOP_W-1:0] left_q, left_d;
  logic              end_q, end_d;
  logic              accept, step_adv, rewind, finishing;
  logic              div_done, at_last;
  logic [CODE_W-1:0] div_quo;
  logic [STEP_W-1:0] div_rem;

  ramp_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  ramp_divider #(.DVD_W(CODE_W), .DVS_W(STEP_W)) u_div (
    .clk(clk), .rst_n(rst_n_i), .go(accept),
    .dividend(cfg_span), .divisor(cfg_steps),
    .done(div_done), .quotient(div_quo), .remainder(div_rem)
  );

  ramp_stepper #(.CODE_W(CODE_W), .STEP_W(STEP_W)) u_step (
    .clk(clk), .rst_n(rst_n_i),
    .load(accept), .rewind(rewind), .adv(step_adv),
    .base_in(cfg_start_code), .quo(div_quo), .rem(div_rem),
    .steps(steps_q), .code(code_out), .at_last(at_last)
  );

  always_comb begin
    accept    = start && (cfg_steps != '0) &&
                ((state_q == ST_IDLE) || (state_q == ST_DONE));
    step_adv  = (state_q == ST_RUN) && upd;
    finishing = step_adv && at_last;
    rewind    = (state_q == ST_HOLD) && upd;
    state_d   = state_q;
    steps_d   = steps_q;
    left_d    = left_q;
    end_d     = finishing;
    case (state_q)
      ST_IDLE, ST_DONE: begin
        if (accept) begin
          state_d = ST_DIV;
          steps_d = cfg_steps;
          left_d  = (cfg_loops == '0) ? LOOP_W'(1) : cfg_loops;
        end
      end
      ST_DIV: begin
        if (div_done) state_d = ST_RUN;
      end
      ST_RUN: begin
        if (finishing) begin
          left_d  = left_q - 1'b1;
          state_d = (left_q == LOOP_W'(1)) ? ST_DONE : ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (upd) state_d = ST_RUN;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q <= ST_IDLE;
      steps_q <= '0;
      left_q  <= '0;
      end_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      steps_q <= steps_d;
      left_q  <= left_d;
      end_q   <= end_d;
    end
  end

  assign ramp_ready = (state_q == ST_RUN) || (state_q == ST_HOLD);
  assign ramp_done  = (state_q == ST_DONE);
  assign ramp_end   = end_q;
endmodule

// File: rtl/ramp_codegen_chk.sv
module ramp_codegen_chk #(
  parameter int CODE_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              upd,
  input logic              start,
  input logic [CODE_W-1:0] code,
  input logic              ready,
  input logic              done,
  input logic              pulse,
  input logic [2:0]        st
);
  import ramp_codegen_pkg::*;

  assert_end_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);

  assert_end_after_upd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> $past(upd));

  assert_code_still_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd && !start) |=> $stable(code));

  assert_code_rising_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'(ST_RUN) && upd) |=> (code >= $past(code)));

  assert_flags_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(ready && done));
endmodule

bind ramp_codegen ramp_codegen_chk #(.CODE_W(CODE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .upd(upd), .start(start), .code(code_out),
  .ready(ramp_ready), .done(ramp_done), .pulse(ramp_end), .st(state_q)
);

// File: tb/ramp_codegen_tb_top.sv
module ramp_codegen_tb_top;
  localparam int CODE_W = 20;
  localparam int STEP_W = 20;
  localparam int LOOP_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [CODE_W-1:0] cfg_start_code = '0;
  logic [CODE_W-1:0] cfg_span = '0;
  logic [STEP_W-1:0] cfg_steps = '0;
  logic [LOOP_W-1:0] cfg_loops = '0;
  logic              start = 1'b0;
  logic              upd = 1'b0;
  logic [CODE_W-1:0] code_out;
  logic              ramp_ready, ramp_done, ramp_end;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  string phase = "R1";

  always #10 clk = ~clk;

  ramp_codegen #(.CODE_W(CODE_W), .STEP_W(STEP_W), .LOOP_W(LOOP_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_start_code(cfg_start_code),
    .cfg_span(cfg_span), .cfg_steps(cfg_steps), .cfg_loops(cfg_loops),
    .start(start), .upd(upd), .code_out(code_out),
    .ramp_ready(ramp_ready), .ramp_done(ramp_done), .ramp_end(ramp_end)
  );

  // behavioural reference: 0 idle, 1 dividing, 2 running, 3 at end, 4 done
  int     m_st = 0;
  int     m_wait = 0;
  longint m_base = 0, m_span = 0, m_n = 1, m_i = 0;
  int     m_left = 0;
  longint m_code = 0;
  bit     m_end = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_code = 0; m_end = 0; m_i = 0;
    end else begin
      m_end = 0;
      case (m_st)
        0, 4: if (start && cfg_steps != 0) begin
          m_base = cfg_start_code; m_span = cfg_span; m_n = cfg_steps;
          m_left = (cfg_loops == 0) ? 1 : int'(cfg_loops);
          m_code = m_base; m_i = 0; m_wait = CODE_W + 1; m_st = 1;
        end
        1: begin
          m_wait--;
          if (m_wait == 0) m_st = 2;
        end
        2: if (upd) begin
          m_i++;
          m_code = m_base + (m_i * m_span) / m_n;
          if (m_i == m_n) begin
            m_end = 1; m_left--;
            m_st = (m_left == 0) ? 4 : 3;
          end
        end
        3: if (upd) begin
          m_i = 0; m_code = m_base; m_st = 2;
        end
        default: m_st = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      total++;
      if (longint'(code_out) != m_code || ramp_end != m_end ||
          ramp_ready != (m_st == 2 || m_st == 3) || ramp_done != (m_st == 4)) begin
        bad++;
        $display("FAIL %s t=%0t code=%0d/%0d end=%0b/%0b ready=%0b/%0b done=%0b/%0b (actual/expected)",
                 phase, $time, code_out, m_code, ramp_end, m_end,
                 ramp_ready, (m_st == 2 || m_st == 3), ramp_done, (m_st == 4));
      end
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go(input longint b, input longint s, input longint n, input int l);
    @(negedge clk);
    cfg_start_code = CODE_W'(b); cfg_span = CODE_W'(s);
    cfg_steps = STEP_W'(n); cfg_loops = LOOP_W'(l);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic updates(input int n, input int gap);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); upd = 1'b1;
      @(negedge clk); upd = 1'b0;
      if (gap > 0) cycles(gap);
    end
  endtask

  task automatic streak(input int n);
    @(negedge clk); upd = 1'b1;
    cycles(n);
    upd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired in phase %s", phase);
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    phase = "R1 reset";
    cycles(4);
    rst_n = 1'b1;
    cycles(4);

    phase = "R6 upd while idle";
    updates(2, 1);

    phase = "R2 zero steps ignored";
    go(500, 50, 0, 1);
    cycles(3);

    phase = "R2/R3/R4 wide step";
    go(10240, 1028096, 13, 2);
    phase = "R6 upd while dividing";
    updates(5, 0);
    cycles(CODE_W);
    phase = "R8 start mid-run";
    go(7, 7, 7, 7);
    phase = "R7 cfg change mid-run";
    cfg_start_code = 3; cfg_span = 9; cfg_steps = 2;
    phase = "R3/R4 gapped steps pass1";
    updates(13, 2);
    phase = "R5 reload pass2";
    streak(14);
    cycles(3);
    phase = "R6 upd after done";
    updates(3, 0);

    phase = "R9 restart fractional";
    go(1000, 5, 8, 0);
    cycles(CODE_W + 2);
    phase = "R3 carry-only steps";
    streak(8);
    cycles(2);

    phase = "R9 zero span loops";
    go(42, 0, 3, 3);
    cycles(CODE_W + 2);
    phase = "R5 three passes";
    updates(11, 1);
    cycles(3);

    phase = "R3 long ramp";
    go(10240, 1028096, 409, 1);
    cycles(CODE_W + 2);
    streak(409);
    cycles(4);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule